// File: doc/BRIEF.md
# Security-Banked Private Interrupt State Bank

This block stores the per-interrupt state of 32 private interrupts, IDs 0 to 15 being software-generated and IDs 16 to 31 peripheral. For each one it keeps a group bit, a group-modifier bit, an enable, a pending and an active flag, an 8-bit priority and a trigger type. Each software-generated interrupt also has a 2-bit non-secure access field. There is one processor-sleep flag for the whole bank. Software reaches all of this through a single register port. The port carries a byte-count field and a flag that marks the access as secure or non-secure. A global input switches the security model off.

With security on, a non-secure access gets a filtered view of the state. Interrupts whose group bit is 0 are hidden from it. Priorities are remapped between the two views, so that a non-secure agent can only ever place an interrupt in the lower half of the priority range. Enable, pending and active state is changed through matching set and clear registers. Arbitration and power signalling belong to neighbouring blocks.

Top module: `irq_state_bank`

## Requirements
- R1: A clock edge with rst_n low clears every group, modifier, enable, pending, active, priority and access field to 0. It sets the peripheral trigger bits to level (0) and sets the sleep flag to 1. The software-generated trigger pairs read as edge.
- R2: Writes to the set-enable, set-pending and set-active registers set only the bits written as 1. All other bits keep their value.
- R3: Writes to the clear-enable, clear-pending and clear-active registers clear only the bits written as 1. A set register and its clear register read back the same state.
- R4: Trigger pairs: an interrupt's pair sits at bits 2j+1:2j of its trigger register, with j = ID for IDs 0..15 (register 0x0A0) and j = ID-16 for IDs 16..31 (register 0x0A4). Bit 2j+1 = 1 means edge-triggered, and bit 2j reads 0. Software-generated pairs always read edge and ignore writes. Peripheral pairs are writable.
- R5: When sec_dis = 0 and req_secure = 0, an interrupt whose group bit is 0 reads 0 and ignores writes in the enable, pending, active, trigger and priority registers. An interrupt whose group bit is 1 is visible, whatever its modifier bit.
- R6: Under the same non-secure condition, a priority read returns the stored byte shifted left by one and truncated to 8 bits. A priority write stores 0x80 | (value >> 1). Secure accesses, and all accesses while sec_dis = 1, use the raw byte.
- R7: req_size values 0, 1, 2 and 3 select 1, 2, 4 and 4 bytes, taken as lanes from bit 0 upward. A bitmap or field register write changes only bits inside those lanes. Lanes outside them read 0. In the priority window 0x400..0x41F, lane k of an access at offset 0x400+n addresses ID n+k, and IDs beyond 31 are ignored.
- R8: The sleep register (bit 0 at 0x000) and the group register read as 0 and ignore writes when sec_dis = 0 and req_secure = 0. The modifier register (0x0B0) and the access register (0x0B4, with SGI i's field at bits 2i+1:2i) read as 0 and ignore writes unless sec_dis = 0 and req_secure = 1.
- R9: An access to any offset not listed in R11 reads 0 and changes no state.
- R10: A write takes effect at the clock edge on which req_wr is high. req_rdata is combinational from the request and the stored state, so during a write cycle it still shows the state before the write.
- R11: The register map is as follows. 0x000 sleep; 0x080 group; 0x084 / 0x088 set / clear enable; 0x08C / 0x090 set / clear pending; 0x094 / 0x098 set / clear active; 0x0A0 / 0x0A4 software / peripheral trigger; 0x0B0 modifier; 0x0B4 access; 0x400..0x41F priority. In every bitmap register, bit i belongs to ID i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_dis | input | 1 | 1 turns the security model off |
| req_wr | input | 1 | Write strobe for the current request |
| req_addr | input | 12 | Byte offset of the register |
| req_size | input | 2 | Byte count code: 0=1, 1=2, 2 or 3=4 |
| req_secure | input | 1 | 1 marks the access as secure |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Combinational read data |

## Verification
The bench looks at non-secure accesses that touch a mix of visible and hidden interrupts. A design that leaks the filter would expose or change hidden pending and priority state. It drives priority accesses that run past ID 31 or start at odd byte offsets; a wrong lane mapping would write the wrong ID or wrap around. Short writes to bitmap registers would show whether upper lanes are wrongly changed. The remaining targets are writes to the software-generated trigger pairs, modifier writes made while security is off, and undefined offsets. Each of these would expose state that should stay fixed.

// File: rtl/irq_bank_pkg.sv
// Package: shared sizes, register offsets and the offset decoder of the
// private interrupt state bank. Assumes NUM_IRQ and 2*NUM_SGI equal DATA_W.
package irq_bank_pkg;
    localparam int NUM_SGI = 16;
    localparam int NUM_PPI = 16;
    localparam int NUM_IRQ = NUM_SGI + NUM_PPI;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 12;
    localparam int PRIO_W  = 8;
    localparam int ID_W    = $clog2(NUM_IRQ);
    localparam int LANES   = DATA_W / PRIO_W;
    localparam int LANE_W  = $clog2(LANES);
    localparam int NB_W    = LANE_W + 1;
    localparam int NSACC_W = 2 * NUM_SGI;

    localparam logic [ADDR_W-1:0] OFS_SLEEP     = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_GROUP     = 12'h080;
    localparam logic [ADDR_W-1:0] OFS_SETEN     = 12'h084;
    localparam logic [ADDR_W-1:0] OFS_CLREN     = 12'h088;
    localparam logic [ADDR_W-1:0] OFS_SETPEND   = 12'h08C;
    localparam logic [ADDR_W-1:0] OFS_CLRPEND   = 12'h090;
    localparam logic [ADDR_W-1:0] OFS_SETACT    = 12'h094;
    localparam logic [ADDR_W-1:0] OFS_CLRACT    = 12'h098;
    localparam logic [ADDR_W-1:0] OFS_CFG_SGI   = 12'h0A0;
    localparam logic [ADDR_W-1:0] OFS_CFG_PPI   = 12'h0A4;
    localparam logic [ADDR_W-1:0] OFS_GRPMOD    = 12'h0B0;
    localparam logic [ADDR_W-1:0] OFS_NSACC     = 12'h0B4;
    localparam logic [ADDR_W-1:0] OFS_PRIO_BASE = 12'h400;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_SLEEP, SEL_GROUP, SEL_SETEN, SEL_CLREN,
        SEL_SETPEND, SEL_CLRPEND, SEL_SETACT, SEL_CLRACT,
        SEL_CFG_SGI, SEL_CFG_PPI, SEL_GRPMOD, SEL_NSACC, SEL_PRIO
    } reg_sel_e;

    // Map a byte offset onto the register it selects.
    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_SLEEP:   s = SEL_SLEEP;
            OFS_GROUP:   s = SEL_GROUP;
            OFS_SETEN:   s = SEL_SETEN;
            OFS_CLREN:   s = SEL_CLREN;
            OFS_SETPEND: s = SEL_SETPEND;
            OFS_CLRPEND: s = SEL_CLRPEND;
            OFS_SETACT:  s = SEL_SETACT;
            OFS_CLRACT:  s = SEL_CLRACT;
            OFS_CFG_SGI: s = SEL_CFG_SGI;
            OFS_CFG_PPI: s = SEL_CFG_PPI;
            OFS_GRPMOD:  s = SEL_GRPMOD;
            OFS_NSACC:   s = SEL_NSACC;
            default: begin
                if ((a >= OFS_PRIO_BASE) &&
                    (a < OFS_PRIO_BASE + ADDR_W'(NUM_IRQ)))
                    s = SEL_PRIO;
                else
                    s = SEL_NONE;
            end
        endcase
        return s;
    endfunction
endpackage

// File: rtl/irq_access_gate.sv
// Access gate: turns the security flags and the byte count of a request
// into a lane mask, a per-interrupt visibility vector and view flags.
// Assumes the group vector comes from registered state.
module irq_access_gate
    import irq_bank_pkg::*;
(
    input  logic               sec_dis,
    input  logic               secure,
    input  logic [1:0]         size,
    input  logic [NUM_IRQ-1:0] grp,
    output logic [DATA_W-1:0]  lane_mask,
    output logic [NUM_IRQ-1:0] vis,
    output logic [NB_W-1:0]    nbytes,
    output logic               ns_view,
    output logic               mod_ok
);
    // Security view and per-interrupt visibility.
    always_comb begin
        ns_view = !sec_dis && !secure;
        mod_ok  = !sec_dis && secure;
        vis     = ns_view ? grp : '1;
    end

    // Byte count from the size code.
    always_comb begin
        case (size)
            2'd0:    nbytes = NB_W'(1);
            2'd1:    nbytes = NB_W'(2);
            default: nbytes = NB_W'(LANES);
        endcase
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_mask[PRIO_W*k +: PRIO_W] = {PRIO_W{(k < int'(nbytes))}};
    end
endmodule

// File: rtl/irq_prio_bank.sv
// Priority store: one byte per interrupt, reached through a byte window.
// Lane k of an access starting at window index base_id hits ID base_id+k.
// Non-secure views are remapped on the way in and out.
module irq_prio_bank
    import irq_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic               hit,
    input  logic [ID_W-1:0]    base_id,
    input  logic [NB_W-1:0]    nbytes,
    input  logic               ns_view,
    input  logic [NUM_IRQ-1:0] vis,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);
    logic [PRIO_W-1:0] prio_q   [NUM_IRQ];
    logic              lane_hit [NUM_IRQ];
    logic [LANE_W-1:0] lane_sel [NUM_IRQ];

    // Which lane, if any, each interrupt takes in this access.
    always_comb begin
        for (int g = 0; g < NUM_IRQ; g++) begin
            lane_hit[g] = (g >= int'(base_id)) &&
                          ((g - int'(base_id)) < int'(nbytes));
            lane_sel[g] = LANE_W'(g - int'(base_id));
        end
    end

    // Store written bytes, remapping non-secure values into the low half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_IRQ; g++) prio_q[g] <= '0;
        end else if (wr && hit) begin
            for (int g = 0; g < NUM_IRQ; g++) begin
                if (lane_hit[g] && vis[g]) begin
                    if (ns_view)
                        prio_q[g] <= {1'b1, wdata[PRIO_W*lane_sel[g]+1 +: PRIO_W-1]};
                    else
                        prio_q[g] <= wdata[PRIO_W*lane_sel[g] +: PRIO_W];
                end
            end
        end
    end

    // Gather read lanes, shifting for the non-secure view.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < LANES; k++) begin
            logic [ID_W-1:0] idx;
            idx = base_id + ID_W'(k);
            if (hit && (k < int'(nbytes)) && ((int'(base_id) + k) < NUM_IRQ) && vis[idx])
                rdata[PRIO_W*k +: PRIO_W] = ns_view ? {prio_q[idx][PRIO_W-2:0], 1'b0}
                                                    : prio_q[idx];
        end
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chk
        // R6: a non-secure write leaves the top priority bit set
        assert_ns_prio_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && hit && ns_view && lane_hit[g] && vis[g]) |=> prio_q[g][PRIO_W-1]);
        // R5: hidden interrupts keep their priority under non-secure writes
        assert_ns_prio_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && ns_view && !vis[g]) |=> $stable(prio_q[g]));
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Flag store: group, modifier, enable, pending, active, peripheral trigger,
// access fields and the sleep flag, with set/clear write styles and the
// filtered read mux. Assumes masks arrive from irq_access_gate.
module irq_flag_bank
    import irq_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  reg_sel_e           sel,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  lane_mask,
    input  logic [NUM_IRQ-1:0] vis,
    input  logic               ns_view,
    input  logic               mod_ok,
    output logic [NUM_IRQ-1:0] grp_o,
    output logic [DATA_W-1:0]  rdata
);
    logic [NUM_IRQ-1:0] grp_q, mod_q, en_q, pend_q, act_q;
    logic [NUM_PPI-1:0] cfg_q;
    logic [NSACC_W-1:0] nsacc_q;
    logic               sleep_q;

    logic [NUM_IRQ-1:0] lm_i, wd_i, wm;
    logic [NUM_PPI-1:0] cfg_wm, cfg_wd;

    // Per-bit write masks for bitmaps and trigger pairs.
    always_comb begin
        lm_i = lane_mask[NUM_IRQ-1:0];
        wd_i = wdata[NUM_IRQ-1:0];
        wm   = lm_i & vis;
        for (int i = 0; i < NUM_PPI; i++) begin
            cfg_wm[i] = lane_mask[2*i+1] & vis[NUM_SGI+i];
            cfg_wd[i] = wdata[2*i+1];
        end
    end

    // Register update per selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q   <= '0;
            mod_q   <= '0;
            en_q    <= '0;
            pend_q  <= '0;
            act_q   <= '0;
            cfg_q   <= '0;
            nsacc_q <= '0;
            sleep_q <= 1'b1;
        end else if (wr) begin
            case (sel)
                SEL_SLEEP:   if (!ns_view) sleep_q <= wdata[0];
                SEL_GROUP:   if (!ns_view) grp_q <= (grp_q & ~lm_i) | (wd_i & lm_i);
                SEL_SETEN:   en_q   <= en_q   | (wd_i & wm);
                SEL_CLREN:   en_q   <= en_q   & ~(wd_i & wm);
                SEL_SETPEND: pend_q <= pend_q | (wd_i & wm);
                SEL_CLRPEND: pend_q <= pend_q & ~(wd_i & wm);
                SEL_SETACT:  act_q  <= act_q  | (wd_i & wm);
                SEL_CLRACT:  act_q  <= act_q  & ~(wd_i & wm);
                SEL_CFG_PPI: cfg_q  <= (cfg_q & ~cfg_wm) | (cfg_wd & cfg_wm);
                SEL_GRPMOD:  if (mod_ok) mod_q <= (mod_q & ~lm_i) | (wd_i & lm_i);
                SEL_NSACC:   if (mod_ok) nsacc_q <= (nsacc_q & ~lane_mask[NSACC_W-1:0]) |
                                                    (wdata[NSACC_W-1:0] & lane_mask[NSACC_W-1:0]);
                default: ;
            endcase
        end
    end

    // Filtered read mux; set and clear offsets share one view.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_SLEEP:   rdata[0] = !ns_view && sleep_q;
            SEL_GROUP:   rdata = ns_view ? '0 : DATA_W'(grp_q);
            SEL_SETEN, SEL_CLREN:     rdata = DATA_W'(en_q & vis);
            SEL_SETPEND, SEL_CLRPEND: rdata = DATA_W'(pend_q & vis);
            SEL_SETACT, SEL_CLRACT:   rdata = DATA_W'(act_q & vis);
            SEL_CFG_SGI: for (int i = 0; i < NUM_SGI; i++) rdata[2*i+1] = vis[i];
            SEL_CFG_PPI: for (int i = 0; i < NUM_PPI; i++) rdata[2*i+1] = cfg_q[i] & vis[NUM_SGI+i];
            SEL_GRPMOD:  rdata = mod_ok ? DATA_W'(mod_q) : '0;
            SEL_NSACC:   rdata = mod_ok ? DATA_W'(nsacc_q) : '0;
            default: ;
        endcase
    end

    assign grp_o = grp_q;

    // R2: set-style writes never clear a bit
    assert_set_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (sel == SEL_SETEN || sel == SEL_SETPEND || sel == SEL_SETACT)) |=>
        (((en_q & $past(en_q)) == $past(en_q)) && ((pend_q & $past(pend_q)) == $past(pend_q)) &&
         ((act_q & $past(act_q)) == $past(act_q))));
    // R3: clear-style writes never set a bit
    assert_clear_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (sel == SEL_CLREN || sel == SEL_CLRPEND || sel == SEL_CLRACT)) |=>
        (((en_q | $past(en_q)) == $past(en_q)) && ((pend_q | $past(pend_q)) == $past(pend_q)) &&
         ((act_q | $past(act_q)) == $past(act_q))));
    // R5: non-secure writes leave hidden interrupts untouched
    assert_ns_filter_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ns_view) |=> ((((en_q ^ $past(en_q)) | (pend_q ^ $past(pend_q)) |
                              (act_q ^ $past(act_q))) & ~$past(grp_q)) == '0));
    // R8: modifier and access fields only move under a secure write with security on
    assert_mod_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !mod_ok) |=> ($stable(mod_q) && $stable(nsacc_q)));
    // R9: undefined offsets change nothing
    assert_undef_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_NONE) |=> ($stable(grp_q) && $stable(en_q) && $stable(pend_q) &&
                                     $stable(act_q) && $stable(cfg_q) && $stable(sleep_q)));
endmodule

// File: rtl/irq_state_bank.sv
// Top: per-interrupt state bank for 32 private interrupts with a secure /
// non-secure register port. Decodes the offset, gates the access and
// merges the priority and flag read paths. Reads are combinational.
module irq_state_bank
    import irq_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_dis,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_secure,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] req_rdata
);
    reg_sel_e           sel;
    logic [ID_W-1:0]    prio_base;
    logic [DATA_W-1:0]  lane_mask, prio_rd, flag_rd;
    logic [NUM_IRQ-1:0] vis, grp;
    logic [NB_W-1:0]    nbytes;
    logic               ns_view, mod_ok;

    // Offset decode and priority window index.
    always_comb begin
        sel       = decode_offset(req_addr);
        prio_base = ID_W'(req_addr - OFS_PRIO_BASE);
    end

    irq_access_gate i_gate (
        .sec_dis   (sec_dis),
        .secure    (req_secure),
        .size      (req_size),
        .grp       (grp),
        .lane_mask (lane_mask),
        .vis       (vis),
        .nbytes    (nbytes),
        .ns_view   (ns_view),
        .mod_ok    (mod_ok)
    );

    irq_prio_bank i_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (req_wr),
        .hit     (sel == SEL_PRIO),
        .base_id (prio_base),
        .nbytes  (nbytes),
        .ns_view (ns_view),
        .vis     (vis),
        .wdata   (req_wdata),
        .rdata   (prio_rd)
    );

    irq_flag_bank i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (req_wr),
        .sel       (sel),
        .wdata     (req_wdata),
        .lane_mask (lane_mask),
        .vis       (vis),
        .ns_view   (ns_view),
        .mod_ok    (mod_ok),
        .grp_o     (grp),
        .rdata     (flag_rd)
    );

    // Merge read paths and clip to the accessed lanes.
    assign req_rdata = ((sel == SEL_PRIO) ? prio_rd : flag_rd) & lane_mask;
endmodule

// File: tb/test_irq_state_bank.sv
module test_irq_state_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_dis = 1'b0;
    logic        req_wr = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_secure = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state
    logic [31:0] m_grp, m_mod, m_en, m_pend, m_act, m_nsacc;
    logic [15:0] m_cfg;
    logic        m_sleep;
    logic [7:0]  m_prio [32];

    always #10 clk = ~clk;

    irq_state_bank i_irq_state_bank (
        .clk(clk), .rst_n(rst_n), .sec_dis(sec_dis), .req_wr(req_wr),
        .req_addr(req_addr), .req_size(req_size), .req_secure(req_secure),
        .req_wdata(req_wdata), .req_rdata(req_rdata)
    );

    function automatic logic [31:0] lanes(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic int nb_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a, input logic [1:0] sz,
                                               input logic sec);
        logic ns, mok;
        logic [31:0] v, r;
        ns  = !sec_dis && !sec;
        mok = !sec_dis && sec;
        v   = ns ? m_grp : 32'hFFFF_FFFF;
        r   = '0;
        case (a)
            12'h000: r = ns ? 32'h0 : {31'b0, m_sleep};
            12'h080: r = ns ? 32'h0 : m_grp;
            12'h084, 12'h088: r = m_en & v;
            12'h08C, 12'h090: r = m_pend & v;
            12'h094, 12'h098: r = m_act & v;
            12'h0A0: for (int i = 0; i < 16; i++) r[2*i+1] = v[i];
            12'h0A4: for (int i = 0; i < 16; i++) r[2*i+1] = m_cfg[i] & v[16+i];
            12'h0B0: r = mok ? m_mod : 32'h0;
            12'h0B4: r = mok ? m_nsacc : 32'h0;
            default: begin
                if (a >= 12'h400 && a < 12'h420) begin
                    for (int k = 0; k < nb_of(sz); k++) begin
                        int id;
                        id = int'(a) - 'h400 + k;
                        if (id < 32 && v[id])
                            r[8*k +: 8] = ns ? {m_prio[id][6:0], 1'b0} : m_prio[id];
                    end
                end
            end
        endcase
        return r & lanes(sz);
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [1:0] sz, input logic sec,
                               input logic [31:0] d);
        logic ns, mok;
        logic [31:0] v, lm, wm;
        ns  = !sec_dis && !sec;
        mok = !sec_dis && sec;
        v   = ns ? m_grp : 32'hFFFF_FFFF;
        lm  = lanes(sz);
        wm  = lm & v;
        case (a)
            12'h000: if (!ns) m_sleep = d[0];
            12'h080: if (!ns) m_grp = (m_grp & ~lm) | (d & lm);
            12'h084: m_en   = m_en | (d & wm);
            12'h088: m_en   = m_en & ~(d & wm);
            12'h08C: m_pend = m_pend | (d & wm);
            12'h090: m_pend = m_pend & ~(d & wm);
            12'h094: m_act  = m_act | (d & wm);
            12'h098: m_act  = m_act & ~(d & wm);
            12'h0A4: for (int i = 0; i < 16; i++)
                         if (lm[2*i+1] && v[16+i]) m_cfg[i] = d[2*i+1];
            12'h0B0: if (mok) m_mod = (m_mod & ~lm) | (d & lm);
            12'h0B4: if (mok) m_nsacc = (m_nsacc & ~lm) | (d & lm);
            default: begin
                if (a >= 12'h400 && a < 12'h420) begin
                    for (int k = 0; k < nb_of(sz); k++) begin
                        int id;
                        id = int'(a) - 'h400 + k;
                        if (id < 32 && v[id])
                            m_prio[id] = ns ? {1'b1, d[8*k+1 +: 7]} : d[8*k +: 8];
                    end
                end
            end
        endcase
    endtask

    function automatic string req_tag(input logic [11:0] a);
        if (a == 12'h000 || a == 12'h080 || a == 12'h0B0 || a == 12'h0B4) return "R8 R11";
        if (a >= 12'h084 && a <= 12'h098 && a[1:0] == 2'b00) return "R2 R3 R5 R7";
        if (a == 12'h0A0 || a == 12'h0A4) return "R4 R5";
        if (a >= 12'h400 && a < 12'h420) return "R6 R7 R5";
        return "R9";
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [11:0] a, input logic [1:0] sz, input logic sec,
                           input string tag);
        @(negedge clk);
        req_wr = 1'b0; req_addr = a; req_size = sz; req_secure = sec;
        #1;
        check(req_rdata, model_read(a, sz, sec), tag);
    endtask

    // Write, checking that the read port still shows the old state (R10).
    task automatic do_write(input logic [11:0] a, input logic [1:0] sz, input logic sec,
                            input logic [31:0] d);
        @(negedge clk);
        req_wr = 1'b1; req_addr = a; req_size = sz; req_secure = sec; req_wdata = d;
        #1;
        check(req_rdata, model_read(a, sz, sec), "R10 pre-edge read");
        @(negedge clk);
        req_wr = 1'b0;
        model_write(a, sz, sec, d);
    endtask

    function automatic logic [11:0] defined_ofs(input int idx);
        case (idx)
            0: return 12'h000;  1: return 12'h080;  2: return 12'h084;
            3: return 12'h088;  4: return 12'h08C;  5: return 12'h090;
            6: return 12'h094;  7: return 12'h098;  8: return 12'h0A0;
            9: return 12'h0A4; 10: return 12'h0B0; 11: return 12'h0B4;
            default: return 12'h400;
        endcase
    endfunction

    task automatic print_summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        print_summary();
        $finish;
    end

    initial begin
        int seed;
        m_grp = '0; m_mod = '0; m_en = '0; m_pend = '0; m_act = '0; m_nsacc = '0;
        m_cfg = '0; m_sleep = 1'b1;
        for (int i = 0; i < 32; i++) m_prio[i] = '0;
        seed = $urandom(32'd2024);

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 R11: reset values, read securely
        do_read(12'h000, 2'd2, 1'b1, "R1 R11 sleep");
        do_read(12'h080, 2'd2, 1'b1, "R1 R11 group");
        do_read(12'h084, 2'd2, 1'b1, "R1 R11 enable");
        do_read(12'h08C, 2'd2, 1'b1, "R1 R11 pending");
        do_read(12'h094, 2'd2, 1'b1, "R1 R11 active");
        do_read(12'h0A0, 2'd2, 1'b1, "R1 R11 sgi trigger");
        check(req_rdata, 32'hAAAA_AAAA, "R1 sgi edge literal");
        do_read(12'h0A4, 2'd2, 1'b1, "R1 R11 ppi trigger");
        do_read(12'h0B0, 2'd2, 1'b1, "R1 R11 modifier");
        do_read(12'h0B4, 2'd2, 1'b1, "R1 R11 access");
        for (int w = 0; w < 8; w++) do_read(12'h400 + 12'(4*w), 2'd2, 1'b1, "R1 priority");

        // R2 R3: set and clear styles
        do_write(12'h084, 2'd2, 1'b1, 32'h0000_00F0);
        do_write(12'h084, 2'd2, 1'b1, 32'h0000_000F);
        do_read(12'h084, 2'd2, 1'b1, "R2 set accumulates");
        check(req_rdata, 32'h0000_00FF, "R2 literal");
        do_write(12'h088, 2'd2, 1'b1, 32'h0000_003C);
        do_read(12'h088, 2'd2, 1'b1, "R3 clear view");
        check(req_rdata, 32'h0000_00C3, "R3 literal");
        do_read(12'h084, 2'd2, 1'b1, "R3 set view equal");

        // R4: trigger pairs
        do_write(12'h0A0, 2'd2, 1'b1, 32'h0);
        do_read(12'h0A0, 2'd2, 1'b1, "R4 sgi fixed");
        do_write(12'h0A4, 2'd2, 1'b1, 32'h0000_000A);
        do_read(12'h0A4, 2'd2, 1'b1, "R4 ppi writable");

        // R5: non-secure filter
        do_write(12'h080, 2'd2, 1'b1, 32'h0000_FFFF);
        do_write(12'h08C, 2'd2, 1'b1, 32'hFFFF_FFFF);
        do_read(12'h08C, 2'd2, 1'b0, "R5 ns pending view");
        do_write(12'h090, 2'd2, 1'b0, 32'hFFFF_FFFF);
        do_read(12'h08C, 2'd2, 1'b1, "R5 hidden kept");
        check(req_rdata, 32'hFFFF_0000, "R5 literal");

        // R6: priority remap
        do_write(12'h401, 2'd0, 1'b1, 32'h0000_0040);
        do_read(12'h401, 2'd0, 1'b0, "R6 ns read shift");
        check(req_rdata, 32'h0000_0080, "R6 literal read");
        do_write(12'h402, 2'd0, 1'b0, 32'h0000_0040);
        do_read(12'h402, 2'd0, 1'b1, "R6 ns write remap");
        check(req_rdata, 32'h0000_00A0, "R6 literal write");
        do_write(12'h414, 2'd0, 1'b0, 32'h0000_0033);
        do_read(12'h414, 2'd0, 1'b1, "R5 R6 hidden priority");

        // R7: lanes and window edges
        do_write(12'h404, 2'd2, 1'b1, 32'h4433_2211);
        do_read(12'h405, 2'd0, 1'b1, "R7 byte lane");
        check(req_rdata, 32'h0000_0022, "R7 literal");
        do_write(12'h41E, 2'd3, 1'b1, 32'hDDCC_BBAA);
        do_read(12'h41C, 2'd2, 1'b1, "R7 past end");
        do_read(12'h400, 2'd2, 1'b1, "R7 no wrap");
        do_write(12'h094, 2'd0, 1'b1, 32'hFFFF_FFFF);
        do_read(12'h094, 2'd2, 1'b1, "R7 short bitmap write");

        // R8: restricted registers
        do_write(12'h080, 2'd2, 1'b0, 32'h0);
        do_read(12'h080, 2'd2, 1'b1, "R8 ns group ignored");
        do_write(12'h000, 2'd2, 1'b0, 32'h0);
        do_read(12'h000, 2'd2, 1'b1, "R8 ns sleep ignored");
        do_write(12'h0B4, 2'd2, 1'b1, 32'h1234_5678);
        do_read(12'h0B4, 2'd2, 1'b1, "R8 access secure");
        @(negedge clk) sec_dis = 1'b1;
        do_write(12'h0B0, 2'd2, 1'b1, 32'hFFFF_FFFF);
        do_read(12'h0B0, 2'd2, 1'b1, "R8 modifier off with sec_dis");
        @(negedge clk) sec_dis = 1'b0;
        do_read(12'h0B0, 2'd2, 1'b1, "R8 modifier unchanged");

        // R9: undefined offsets
        do_write(12'h0FC, 2'd2, 1'b1, 32'hFFFF_FFFF);
        do_read(12'h0FC, 2'd2, 1'b1, "R9 reads zero");
        do_read(12'h084, 2'd2, 1'b1, "R9 enable untouched");
        do_read(12'h0A4, 2'd2, 1'b1, "R9 trigger untouched");

        // Random mix against the model
        for (int n = 0; n < 600; n++) begin
            int pick;
            logic [11:0] a;
            logic [1:0]  sz;
            logic        sec;
            pick = $urandom_range(0, 15);
            if (pick < 12)       a = defined_ofs(pick);
            else if (pick < 15)  a = 12'h400 + 12'($urandom_range(0, 31));
            else                 a = 12'h200 + 12'($urandom_range(0, 255));
            sz  = 2'($urandom_range(0, 3));
            sec = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 7) == 0) begin
                @(negedge clk) sec_dis = ~sec_dis;
            end
            if ($urandom_range(0, 1) == 1) do_write(a, sz, sec, $urandom());
            do_read(a, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), req_tag(a));
        end

        print_summary();
        $finish;
    end
endmodule